// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block tracks decoded instructions from the point where they enter the out-of-order core until they leave it. It is a circular queue. Decode presents up to W instructions per cycle, packed from lane 0 upward. Each accepted instruction takes the next free slot. The index of that slot is handed back to decode as the instruction's physical destination tag. There are exactly as many physical registers as slots, so no separate free list is needed. When the queue cannot take a full group of W, it drops its ready output and decode holds fetch.

Execution units report finished instructions on W completion ports. Each report names a tag and carries a mispredict flag and a corrected PC. The oldest instructions leave from the head in program order, up to W per cycle. A retired tag marks the moment its destination value becomes architecturally visible. When a mispredicted branch retires, the block presents a one-cycle redirect carrying the corrected PC, and fetch restarts from that address on the next cycle.

Top module: `rob_core`

## Requirements
- R1: After synchronous reset, alloc_ready is 1, ret_valid and redirect_valid are 0, and alloc_tag lane i reads i.
- R2: Valid allocation lanes are packed from lane 0. Lane i of an accepted group receives tag (tail+i) mod DEPTH. The tail advances by the number of valid lanes, so a single-lane group advances it by one.
- R3: alloc_ready is a registered flag that is 1 exactly when at least W slots are free. While it is 0, alloc_valid is ignored and the tags do not move.
- R4: A completion port with cmp_valid set marks its tag complete and stores that port's mispredict bit and target PC for the slot.
- R5: Retirement is in program order from the head, up to W per cycle. ret_valid is a thermometer code (lane 0 first). ret_tag lane i equals the head before the retiring edge plus i, modulo DEPTH.
- R6: A retiring group stops at the first slot from the head that is not complete, even if younger slots are complete.
- R7: A completed mispredicted slot is the last slot of its retiring group. On the same cycle it is retired, redirect_valid is 1 for that cycle and redirect_pc carries its stored target.
- R8: A slot whose completion is captured at clock edge e is retired no earlier than edge e+1. Retire and redirect outputs are registered.
- R9: Exactly DEPTH slots can be occupied at once. Head, tail and tags wrap modulo DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | W | Decode lanes requesting a slot, packed from lane 0 |
| alloc_ready | output | 1 | At least W free slots; low means stall fetch |
| alloc_tag | output | W*TAG_W | Tag that each lane receives if accepted |
| cmp_valid | input | W | Completion port valid flags |
| cmp_tag | input | W*TAG_W | Completion port tags |
| cmp_mispred | input | W | Completion port mispredict flags |
| cmp_target | input | W*PC_W | Completion port corrected PCs |
| ret_valid | output | W | Retiring lanes, thermometer coded |
| ret_tag | output | W*TAG_W | Tags made architecturally visible |
| redirect_valid | output | 1 | Corrected PC is presented to fetch this cycle |
| redirect_pc | output | PC_W | Corrected PC |

## Verification
The assertions check the following on every cycle: occupancy never exceeds the depth; alloc_ready is low whenever fewer than W slots are free; occupancy never grows while alloc_ready is low; retire lanes form a thermometer that starts at the previous head; and a redirect always comes with a retirement. Other behaviours need the bench's scenarios. These are: the head blocking younger completed work, a mispredicted branch cutting its group short in either lane, the one-cycle completion-to-retire latency, the stall releasing once space frees, and tags wrapping in order through many fills.

// File: rtl/rob_pkg.sv
package rob_pkg;
  // Modular add for ring indices; off must be below depth.
  function automatic int ring_add(int base, int off, int depth);
    int s;
    s = base + off;
    return (s >= depth) ? s - depth : s;
  endfunction
endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
  parameter int DEPTH = 64,
  parameter int W     = 2,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int LW    = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LW-1:0]    alloc_n,
  input  logic [LW-1:0]    ret_n,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic [CNT_W-1:0] occ,
  output logic             ready
);
  import rob_pkg::*;

  logic [CNT_W-1:0] occ_nx;
  logic [TAG_W-1:0] head_nx, tail_nx;

  always_comb begin
    occ_nx  = occ + CNT_W'(alloc_n) - CNT_W'(ret_n);
    head_nx = TAG_W'(ring_add(int'(head), int'(ret_n), DEPTH));
    tail_nx = TAG_W'(ring_add(int'(tail), int'(alloc_n), DEPTH));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      occ   <= '0;
      ready <= 1'b1;
    end else begin
      head  <= head_nx;
      tail  <= tail_nx;
      occ   <= occ_nx;
      ready <= (occ_nx <= CNT_W'(DEPTH - W));
    end
  end
endmodule

// File: rtl/rob_entry_store.sv
module rob_entry_store #(
  parameter int DEPTH = 64,
  parameter int W     = 2,
  parameter int PC_W  = 32,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int LW    = $clog2(W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TAG_W-1:0]   tail,
  input  logic [LW-1:0]      alloc_n,
  input  logic [TAG_W-1:0]   head,
  input  logic [W-1:0]       cmp_valid,
  input  logic [W*TAG_W-1:0] cmp_tag,
  input  logic [W-1:0]       cmp_mispred,
  input  logic [W*PC_W-1:0]  cmp_target,
  output logic [W-1:0]       win_done,
  output logic [W-1:0]       win_mis,
  output logic [W*PC_W-1:0]  win_tgt
);
  import rob_pkg::*;

  logic [DEPTH-1:0] done_q;
  logic [DEPTH-1:0] mis_q;
  logic [PC_W-1:0]  tgt_mem [DEPTH];

  // Completion flags: cleared on allocation, set on completion.
  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= '0;
    end else begin
      for (int i = 0; i < W; i++) begin
        if (i < int'(alloc_n))
          done_q[TAG_W'(ring_add(int'(tail), i, DEPTH))] <= 1'b0;
      end
      for (int p = 0; p < W; p++) begin
        if (cmp_valid[p])
          done_q[cmp_tag[p*TAG_W +: TAG_W]] <= 1'b1;
      end
    end
  end

  // Per-slot branch outcome, no reset needed.
  always_ff @(posedge clk) begin
    for (int p = 0; p < W; p++) begin
      if (cmp_valid[p]) begin
        mis_q[cmp_tag[p*TAG_W +: TAG_W]]   <= cmp_mispred[p];
        tgt_mem[cmp_tag[p*TAG_W +: TAG_W]] <= cmp_target[p*PC_W +: PC_W];
      end
    end
  end

  // Window of the W oldest slots.
  always_comb begin
    for (int i = 0; i < W; i++) begin
      win_done[i]               = done_q[TAG_W'(ring_add(int'(head), i, DEPTH))];
      win_mis[i]                = mis_q[TAG_W'(ring_add(int'(head), i, DEPTH))];
      win_tgt[i*PC_W +: PC_W]   = tgt_mem[TAG_W'(ring_add(int'(head), i, DEPTH))];
    end
  end
endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel #(
  parameter int DEPTH = 64,
  parameter int W     = 2,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int LW     = $clog2(W + 1),
  localparam int LANE_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [CNT_W-1:0]  occ,
  input  logic [W-1:0]      win_done,
  input  logic [W-1:0]      win_mis,
  output logic [LW-1:0]     ret_n,
  output logic              redir,
  output logic [LANE_W-1:0] redir_lane
);
  logic stop;

  always_comb begin
    ret_n      = '0;
    redir      = 1'b0;
    redir_lane = '0;
    stop       = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (!stop && (i < int'(occ)) && win_done[i]) begin
        ret_n = LW'(i + 1);
        if (win_mis[i]) begin
          redir      = 1'b1;
          redir_lane = LANE_W'(i);
          stop       = 1'b1;
        end
      end else begin
        stop = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rob_core.sv
module rob_core #(
  parameter int DEPTH = 64,
  parameter int W     = 2,
  parameter int PC_W  = 32,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [W-1:0]       alloc_valid,
  output logic               alloc_ready,
  output logic [W*TAG_W-1:0] alloc_tag,
  input  logic [W-1:0]       cmp_valid,
  input  logic [W*TAG_W-1:0] cmp_tag,
  input  logic [W-1:0]       cmp_mispred,
  input  logic [W*PC_W-1:0]  cmp_target,
  output logic [W-1:0]       ret_valid,
  output logic [W*TAG_W-1:0] ret_tag,
  output logic               redirect_valid,
  output logic [PC_W-1:0]    redirect_pc
);
  import rob_pkg::*;

  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int LW     = $clog2(W + 1);
  localparam int LANE_W = (W > 1) ? $clog2(W) : 1;

  logic [TAG_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  occ_q;
  logic [LW-1:0]     alloc_n, ret_n;
  logic [W-1:0]      win_done, win_mis;
  logic [W*PC_W-1:0] win_tgt;
  logic              redir;
  logic [LANE_W-1:0] redir_lane;

  assign alloc_n = alloc_ready ? LW'($countones(alloc_valid)) : '0;

  always_comb begin
    for (int i = 0; i < W; i++)
      alloc_tag[i*TAG_W +: TAG_W] = TAG_W'(ring_add(int'(tail_q), i, DEPTH));
  end

  rob_ptr_ctrl #(.DEPTH(DEPTH), .W(W)) u_ptr (
    .clk(clk), .rst(rst), .alloc_n(alloc_n), .ret_n(ret_n),
    .head(head_q), .tail(tail_q), .occ(occ_q), .ready(alloc_ready)
  );

  rob_entry_store #(.DEPTH(DEPTH), .W(W), .PC_W(PC_W)) u_store (
    .clk(clk), .rst(rst), .tail(tail_q), .alloc_n(alloc_n), .head(head_q),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_mispred(cmp_mispred),
    .cmp_target(cmp_target), .win_done(win_done), .win_mis(win_mis),
    .win_tgt(win_tgt)
  );

  rob_retire_sel #(.DEPTH(DEPTH), .W(W)) u_sel (
    .occ(occ_q), .win_done(win_done), .win_mis(win_mis),
    .ret_n(ret_n), .redir(redir), .redir_lane(redir_lane)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_valid      <= '0;
      ret_tag        <= '0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
    end else begin
      for (int i = 0; i < W; i++) begin
        ret_valid[i]                <= (i < int'(ret_n));
        ret_tag[i*TAG_W +: TAG_W]   <= TAG_W'(ring_add(int'(head_q), i, DEPTH));
      end
      redirect_valid <= redir;
      if (redir)
        redirect_pc <= win_tgt[int'(redir_lane)*PC_W +: PC_W];
    end
  end
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
  parameter int DEPTH = 64,
  parameter int W     = 2,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               alloc_ready,
  input logic [W-1:0]       ret_valid,
  input logic [W*TAG_W-1:0] ret_tag,
  input logic               redirect_valid,
  input logic [TAG_W-1:0]   head,
  input logic [CNT_W-1:0]   occ
);
  // R9
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= CNT_W'(DEPTH));

  // R3
  low_space_chk: assert property (@(posedge clk) disable iff (rst)
    (occ > CNT_W'(DEPTH - W)) |-> !alloc_ready);

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !alloc_ready |=> occ <= $past(occ));

  // R5
  thermo_chk: assert property (@(posedge clk) disable iff (rst)
    (W'(ret_valid + 1'b1) & ret_valid) == '0);

  // R5
  ret_head_chk: assert property (@(posedge clk) disable iff (rst)
    ret_valid[0] |-> ret_tag[TAG_W-1:0] == $past(head));

  // R7
  redir_ret_chk: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> ret_valid[0]);
endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH), .W(W)) u_chk (
  .clk(clk), .rst(rst), .alloc_ready(alloc_ready), .ret_valid(ret_valid),
  .ret_tag(ret_tag), .redirect_valid(redirect_valid), .head(head_q),
  .occ(occ_q)
);

// File: tb/rob_core_tb.sv
module rob_core_tb;
  localparam int DEPTH = 8;
  localparam int W     = 2;
  localparam int PC_W  = 16;
  localparam int TW    = 3;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rst;
  logic [W-1:0] alloc_valid, cmp_valid, cmp_mispred, ret_valid;
  logic alloc_ready, redirect_valid;
  logic [W*TW-1:0] alloc_tag, cmp_tag, ret_tag;
  logic [W*PC_W-1:0] cmp_target;
  logic [PC_W-1:0] redirect_pc;

  int total = 0, bad = 0, exp_ret = 0, ret_count = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rob_core #(.DEPTH(DEPTH), .W(W), .PC_W(PC_W)) u_dut (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_tag(alloc_tag), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
    .cmp_mispred(cmp_mispred), .cmp_target(cmp_target), .ret_valid(ret_valid),
    .ret_tag(ret_tag), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic complete(int t0, int v0, int m0, int p0,
                          int t1, int v1, int m1, int p1);
    cmp_valid   = {v1[0], v0[0]};
    cmp_tag     = {t1[TW-1:0], t0[TW-1:0]};
    cmp_mispred = {m1[0], m0[0]};
    cmp_target  = {p1[PC_W-1:0], p0[PC_W-1:0]};
  endtask

  // R5 R9: retirement order tracked arithmetically, modulo DEPTH
  always @(negedge clk) begin
    if (!rst) begin
      if (ret_valid == 2'b10) begin
        total++; bad++;
        $display("FAIL R5 actual=%0d expected=thermometer", ret_valid);
      end
      for (int i = 0; i < W; i++) begin
        if (ret_valid[i]) begin
          chk("R5_order", int'(ret_tag[i*TW +: TW]), exp_ret);
          exp_ret = (exp_ret + 1) % DEPTH;
          ret_count++;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1; alloc_valid = 0;
    complete(0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); cyc(); cyc();
    rst = 0;
    // R1
    chk("R1_ready", alloc_ready, 1);
    chk("R1_ret", ret_valid, 0);
    chk("R1_redir", redirect_valid, 0);
    chk("R1_tag0", alloc_tag[TW-1:0], 0);
    chk("R1_tag1", alloc_tag[2*TW-1:TW], 1);

    // R9 R3: fill all slots in pairs
    alloc_valid = 2'b11;
    for (int k = 0; k < 4; k++) begin
      cyc();
      chk("R2_tag", alloc_tag[TW-1:0], (2*(k+1)) % DEPTH);
      if (k < 3) chk("R3_ready_open", alloc_ready, 1);
    end
    chk("R3_full", alloc_ready, 0);
    // R3: request while stalled is ignored
    cyc();
    chk("R3_ignored_tag", alloc_tag[TW-1:0], 0);
    chk("R3_still_full", alloc_ready, 0);
    alloc_valid = 0;

    // R6: younger complete, head not
    complete(1, 1, 0, 0, 0, 0, 0, 0);
    cyc();
    complete(0, 0, 0, 0, 0, 0, 0, 0);
    cyc();
    chk("R6_blocked", ret_valid, 0);
    cyc();
    chk("R6_blocked_late", ret_valid, 0);

    // R8 R4: head completes, retires one edge later with its neighbour
    complete(0, 1, 0, 0, 0, 0, 0, 0);
    cyc();
    complete(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R8_not_yet", ret_valid, 0);
    cyc();
    chk("R5_pair", ret_valid, 3);
    chk("R3_released", alloc_ready, 1);

    // R5: remaining slots, two per cycle
    complete(2, 1, 0, 0, 3, 1, 0, 0); cyc();
    complete(4, 1, 0, 0, 5, 1, 0, 0); cyc();
    complete(6, 1, 0, 0, 7, 1, 0, 0); cyc();
    complete(0, 0, 0, 0, 0, 0, 0, 0);
    cyc(); cyc(); cyc();
    chk("R5_drained", ret_count, 8);
    chk("R9_empty_ready", alloc_ready, 1);

    // R7: mispredict in lane 0 cuts the group
    alloc_valid = 2'b11; cyc(); alloc_valid = 0;
    complete(0, 1, 1, 16'hABCD, 1, 1, 0, 0); cyc();
    complete(0, 0, 0, 0, 0, 0, 0, 0); cyc();
    chk("R7_cut", ret_valid, 1);
    chk("R7_redir", redirect_valid, 1);
    chk("R7_pc", redirect_pc, 16'hABCD);
    cyc();
    chk("R7_next", ret_valid, 1);
    chk("R7_pulse", redirect_valid, 0);

    // R7: mispredict in lane 1 ends a full group
    alloc_valid = 2'b11; cyc(); alloc_valid = 0;
    complete(2, 1, 0, 0, 3, 1, 1, 16'h0055); cyc();
    complete(0, 0, 0, 0, 0, 0, 0, 0); cyc();
    chk("R7_lane1_ret", ret_valid, 3);
    chk("R7_lane1_redir", redirect_valid, 1);
    chk("R7_lane1_pc", redirect_pc, 16'h0055);
    cyc();
    chk("R7_lane1_pulse", redirect_valid, 0);

    // R9: wrap through slot 7 to 0
    for (int k = 0; k < 3; k++) begin
      int t;
      t = alloc_tag[TW-1:0];
      alloc_valid = 2'b11; cyc(); alloc_valid = 0;
      complete(t, 1, 0, 0, (t + 1) % DEPTH, 1, 0, 0); cyc();
      complete(0, 0, 0, 0, 0, 0, 0, 0);
    end
    cyc(); cyc(); cyc();
    chk("R9_wrap_count", ret_count, 18);
    chk("R9_wrap_tag", alloc_tag[TW-1:0], 2);

    // R2: single-lane group advances tail by one
    alloc_valid = 2'b01; cyc(); alloc_valid = 0;
    chk("R2_single", alloc_tag[TW-1:0], 3);
    chk("R2_single_l1", alloc_tag[2*TW-1:TW], 4);
    complete(2, 1, 0, 0, 0, 0, 0, 0); cyc();
    complete(0, 0, 0, 0, 0, 0, 0, 0);
    cyc(); cyc();
    chk("R2_single_ret", ret_count, 19);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule